// File: doc/BRIEF.md
# Graphics Masked and Block Write Datapath

This block is the write side of a 32-bit synchronous graphics memory. It keeps two values that persist across operations: a per-bit write mask and a fill color. Both are set by a special mode-set cycle, which is a mode-set command accompanied by the special-function input. The block then shapes every write that reaches the storage array. An ordinary write carries the data bus to one column. Its bit enables are narrowed by the stored mask and by the four byte-mask lines. A block write instead fills up to eight neighbouring columns at once with the stored color. The data bus then supplies, for each byte lane, which of those eight columns receive the fill.

Each accepted command shows up on the outputs one clock later as a single registered beat. That beat carries the target column, the write data, one write enable per column slot, and a 32-bit bit-enable word for every slot. Command decoding other than the special-function qualifier, and the storage array, belong to neighbouring blocks.

Top module: `gfx_write_path`

## Requirements
- R1: After reset the outputs are all zero, the stored mask is all ones and the stored color is zero.
- R2: A mode-set command (cmd_i = 2) with special_i high and col_i[0] = 0 loads dq_i into the stored mask. It produces no write beat.
- R3: A mode-set command with special_i high and col_i[0] = 1 loads dq_i into the stored color. It produces no write beat.
- R4: A write command (cmd_i = 1) with special_i low is an ordinary write. It gives wr_block_o = 0, wr_data_o = dq_i and wr_col_o = col_i, and only slot col_i[2:0] may be enabled.
- R5: dqm_i[j] high clears the enables of data bits 8j+7..8j in every slot, for both kinds of write.
- R6: A write command with special_i high is a block write. It gives wr_block_o = 1, wr_data_o = stored color and wr_col_o = col_i with bits 2..0 cleared. Bit b of slot c is enabled only if dq_i[8*(b/8)+c] is 1.
- R7: Bit b of slot c, at bit_en_o[32c+b], is enabled only if bit b of the stored mask is 1. The mask used is the value stored before the write. Write data never changes the mask.
- R8: col_we_o[c] is 1 exactly when any bit of slot c is enabled.
- R9: A mode-set command with special_i low changes neither stored value and produces no write beat.
- R10: Write outputs appear on the clock edge after the command is sampled. wr_valid_o is 1 only for that beat of a write and zero otherwise, and all other outputs are zero when wr_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command: 0 idle, 1 write, 2 mode-set, 3 unused |
| special_i | input | 1 | Special-function qualifier |
| dq_i | input | 32 | Data bus |
| dqm_i | input | 4 | Byte masks, bit j covers data bits 8j+7..8j |
| col_i | input | 9 | Column address |
| wr_valid_o | output | 1 | Write beat present |
| wr_block_o | output | 1 | Beat is a block write |
| wr_col_o | output | 9 | Column address of the beat (group base for block writes) |
| wr_data_o | output | 32 | Data to write into every enabled slot |
| col_we_o | output | 8 | Write enable per column slot |
| bit_en_o | output | 256 | Bit enables, 32 per slot, slot c at bits 32c+31..32c |

## Verification
The hardest state to reach is a write whose outcome depends on history rather than on the inputs of the same cycle. One case is a block write that mixes a previously loaded mask, a previously loaded color, byte masks and an uneven column pattern per lane. Another is a write that follows ignored or ordinary traffic. The stimulus gets there by loading the mask and color through special cycles first. It then sends ordinary writes and non-special mode-sets whose data would corrupt the stored values if they leaked in. The bench only then issues the block writes that expose both stored values at the ports.

// File: rtl/gwp_pkg.sv
package gwp_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_MODE  = 2'd2,
    CMD_RSVD  = 2'd3
  } gwp_cmd_e;

  typedef struct packed {
    logic wr;
    logic blk;
    logic ld_mask;
    logic ld_color;
  } gwp_op_t;
endpackage

// File: rtl/gwp_rst_sync.sv
module gwp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/gwp_decode.sv
module gwp_decode
  import gwp_pkg::*;
(
  input  logic [1:0] cmd,
  input  logic       special,
  input  logic       sel_color,
  output gwp_op_t    op
);
  gwp_cmd_e cmd_e;

  always_comb begin
    cmd_e       = gwp_cmd_e'(cmd);
    op          = '0;
    op.wr       = (cmd_e == CMD_WRITE);
    op.blk      = (cmd_e == CMD_WRITE) && special;
    op.ld_mask  = (cmd_e == CMD_MODE) && special && !sel_color;
    op.ld_color = (cmd_e == CMD_MODE) && special && sel_color;
  end
endmodule

// File: rtl/gwp_regs.sv
module gwp_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_mask,
  input  logic              ld_color,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] color_q
);
  logic [DATA_W-1:0] mask_d;
  logic [DATA_W-1:0] color_d;

  always_comb begin
    mask_d  = mask_q;
    color_d = color_q;
    if (ld_mask)  mask_d  = din;
    if (ld_color) color_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      color_q <= '0;
    end else begin
      mask_q  <= mask_d;
      color_q <= color_d;
    end
  end
endmodule

// File: rtl/gwp_enable.sv
module gwp_enable #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int NCOL   = 8,
  parameter int COL_W  = 9,
  localparam int NLANE  = DATA_W / LANE_W,
  localparam int CIDX_W = $clog2(NCOL)
) (
  input  logic                   wr,
  input  logic                   blk,
  input  logic [DATA_W-1:0]      mask,
  input  logic [DATA_W-1:0]      color,
  input  logic [DATA_W-1:0]      dq,
  input  logic [NLANE-1:0]       dqm,
  input  logic [COL_W-1:0]       col,
  output logic [NCOL*DATA_W-1:0] bit_en,
  output logic [NCOL-1:0]        col_we,
  output logic [DATA_W-1:0]      wdata,
  output logic [COL_W-1:0]       wcol
);
  logic [CIDX_W-1:0] slot;
  assign slot = col[CIDX_W-1:0];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int LN = b / LANE_W;
      logic pick;
      always_comb begin
        if (blk) pick = dq[LN*LANE_W + c];
        else     pick = (slot == CIDX_W'(c));
      end
      assign bit_en[c*DATA_W + b] = wr & mask[b] & ~dqm[LN] & pick;
    end
    assign col_we[c] = |bit_en[c*DATA_W +: DATA_W];
  end

  always_comb begin
    if (blk) begin
      wdata = color;
      wcol  = {col[COL_W-1:CIDX_W], {CIDX_W{1'b0}}};
    end else begin
      wdata = dq;
      wcol  = col;
    end
  end
endmodule

// File: rtl/gwp_outreg.sv
module gwp_outreg #(
  parameter int DATA_W = 32,
  parameter int NCOL   = 8,
  parameter int COL_W  = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   blk,
  input  logic [COL_W-1:0]       wcol,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [NCOL-1:0]        col_we,
  input  logic [NCOL*DATA_W-1:0] bit_en,
  output logic                   wr_valid_q,
  output logic                   wr_block_q,
  output logic [COL_W-1:0]       wr_col_q,
  output logic [DATA_W-1:0]      wr_data_q,
  output logic [NCOL-1:0]        col_we_q,
  output logic [NCOL*DATA_W-1:0] bit_en_q
);
  logic                   valid_d;
  logic                   block_d;
  logic [COL_W-1:0]       col_d;
  logic [DATA_W-1:0]      data_d;
  logic [NCOL-1:0]        we_d;
  logic [NCOL*DATA_W-1:0] en_d;

  always_comb begin
    valid_d = wr;
    block_d = wr & blk;
    col_d   = wr ? wcol  : '0;
    data_d  = wr ? wdata : '0;
    we_d    = col_we;
    en_d    = bit_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid_q <= 1'b0;
      wr_block_q <= 1'b0;
      wr_col_q   <= '0;
      wr_data_q  <= '0;
      col_we_q   <= '0;
      bit_en_q   <= '0;
    end else begin
      wr_valid_q <= valid_d;
      wr_block_q <= block_d;
      wr_col_q   <= col_d;
      wr_data_q  <= data_d;
      col_we_q   <= we_d;
      bit_en_q   <= en_d;
    end
  end
endmodule

// File: rtl/gfx_write_path.sv
module gfx_write_path
  import gwp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int NCOL   = 8,
  parameter int COL_W  = 9,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cmd_i,
  input  logic                   special_i,
  input  logic [DATA_W-1:0]      dq_i,
  input  logic [NLANE-1:0]       dqm_i,
  input  logic [COL_W-1:0]       col_i,
  output logic                   wr_valid_o,
  output logic                   wr_block_o,
  output logic [COL_W-1:0]       wr_col_o,
  output logic [DATA_W-1:0]      wr_data_o,
  output logic [NCOL-1:0]        col_we_o,
  output logic [NCOL*DATA_W-1:0] bit_en_o
);
  logic                   rst_sync_n;
  gwp_op_t                op;
  logic [DATA_W-1:0]      mask_q;
  logic [DATA_W-1:0]      color_q;
  logic [NCOL*DATA_W-1:0] bit_en;
  logic [NCOL-1:0]        col_we;
  logic [DATA_W-1:0]      wdata;
  logic [COL_W-1:0]       wcol;

  gwp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gwp_decode u_dec (
    .cmd       (cmd_i),
    .special   (special_i),
    .sel_color (col_i[0]),
    .op        (op)
  );

  gwp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ld_mask  (op.ld_mask),
    .ld_color (op.ld_color),
    .din      (dq_i),
    .mask_q   (mask_q),
    .color_q  (color_q)
  );

  gwp_enable #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .NCOL   (NCOL),
    .COL_W  (COL_W)
  ) u_en (
    .wr     (op.wr),
    .blk    (op.blk),
    .mask   (mask_q),
    .color  (color_q),
    .dq     (dq_i),
    .dqm    (dqm_i),
    .col    (col_i),
    .bit_en (bit_en),
    .col_we (col_we),
    .wdata  (wdata),
    .wcol   (wcol)
  );

  gwp_outreg #(
    .DATA_W (DATA_W),
    .NCOL   (NCOL),
    .COL_W  (COL_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr         (op.wr),
    .blk        (op.blk),
    .wcol       (wcol),
    .wdata      (wdata),
    .col_we     (col_we),
    .bit_en     (bit_en),
    .wr_valid_q (wr_valid_o),
    .wr_block_q (wr_block_o),
    .wr_col_q   (wr_col_o),
    .wr_data_q  (wr_data_o),
    .col_we_q   (col_we_o),
    .bit_en_q   (bit_en_o)
  );
endmodule

// File: rtl/gwp_checker.sv
module gwp_checker #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int NCOL   = 8,
  parameter int COL_W  = 9,
  localparam int NLANE  = DATA_W / LANE_W,
  localparam int CIDX_W = $clog2(NCOL)
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic [1:0]             cmd_i,
  input logic                   special_i,
  input logic [DATA_W-1:0]      dq_i,
  input logic [NLANE-1:0]       dqm_i,
  input logic                   wr_valid_o,
  input logic                   wr_block_o,
  input logic [COL_W-1:0]       wr_col_o,
  input logic [DATA_W-1:0]      wr_data_o,
  input logic [NCOL-1:0]        col_we_o,
  input logic [NCOL*DATA_W-1:0] bit_en_o
);
  p_write_beat_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_i == 2'd1) |=> wr_valid_o);

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_i != 2'd1) |=> (!wr_valid_o && col_we_o == '0 && bit_en_o == '0 && wr_data_o == '0));

  p_normal_data_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_i == 2'd1 && !special_i) |=> (wr_data_o == $past(dq_i) && !wr_block_o));

  p_normal_single_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_valid_o && !wr_block_o) |-> $onehot0(col_we_o));

  p_block_align_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_valid_o && wr_block_o) |-> (wr_col_o[CIDX_W-1:0] == '0));

  for (genvar c = 0; c < NCOL; c++) begin : g_c
    p_we_match_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!col_we_o[c]) |-> (bit_en_o[c*DATA_W +: DATA_W] == '0));
    for (genvar j = 0; j < NLANE; j++) begin : g_j
      p_byte_mask_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (cmd_i == 2'd1 && dqm_i[j]) |=> (bit_en_o[c*DATA_W + j*LANE_W +: LANE_W] == '0));
    end
  end
endmodule

bind gfx_write_path gwp_checker #(
  .DATA_W (DATA_W),
  .LANE_W (LANE_W),
  .NCOL   (NCOL),
  .COL_W  (COL_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cmd_i      (cmd_i),
  .special_i  (special_i),
  .dq_i       (dq_i),
  .dqm_i      (dqm_i),
  .wr_valid_o (wr_valid_o),
  .wr_block_o (wr_block_o),
  .wr_col_o   (wr_col_o),
  .wr_data_o  (wr_data_o),
  .col_we_o   (col_we_o),
  .bit_en_o   (bit_en_o)
);

// File: tb/gfx_write_path_bench.sv
`timescale 1ns/1ps
module gfx_write_path_bench;
  logic         clk;
  logic         rst_n;
  logic [1:0]   cmd;
  logic         special;
  logic [31:0]  dq;
  logic [3:0]   dqm;
  logic [8:0]   col;
  logic         wr_valid, wr_block;
  logic [8:0]   wr_col;
  logic [31:0]  wr_data;
  logic [7:0]   col_we;
  logic [255:0] bit_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m_mask, m_color;

  gfx_write_path u_gfx_write_path (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .special_i(special), .dq_i(dq),
    .dqm_i(dqm), .col_i(col), .wr_valid_o(wr_valid), .wr_block_o(wr_block),
    .wr_col_o(wr_col), .wr_data_o(wr_data), .col_we_o(col_we), .bit_en_o(bit_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [255:0] got, logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic [1:0] c, logic s, logic [31:0] d, logic [3:0] m, logic [8:0] a);
    @(negedge clk);
    cmd = c; special = s; dq = d; dqm = m; col = a;
    @(negedge clk);
    cmd = 2'd0; special = 1'b0; dq = '0; dqm = '0; col = '0;
  endtask

  task automatic chk_quiet(string tag);
    chk({tag, " valid"}, 256'(wr_valid), 256'd0);
    chk({tag, " we"}, 256'(col_we), 256'd0);
    chk({tag, " bits"}, bit_en, 256'd0);
  endtask

  task automatic do_write(string tag, logic blk, logic [31:0] d, logic [3:0] m, logic [8:0] a);
    logic [255:0] e_en;
    logic [7:0]   e_we;
    logic         pick;
    e_en = '0;
    e_we = '0;
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < 32; b++) begin
        pick = blk ? d[(b/8)*8 + c] : (int'(a[2:0]) == c);
        e_en[c*32+b] = m_mask[b] & ~m[b/8] & pick;
      end
      e_we[c] = |e_en[c*32 +: 32];
    end
    drive(2'd1, blk, d, m, a);
    chk({tag, " R10 valid"}, 256'(wr_valid), 256'd1);
    chk({tag, " block flag"}, 256'(wr_block), 256'(blk));
    chk({tag, " data"}, 256'(wr_data), 256'(blk ? m_color : d));
    chk({tag, " col"}, 256'(wr_col), 256'(blk ? {a[8:3], 3'b000} : a));
    chk({tag, " R7 bit enables"}, bit_en, e_en);
    chk({tag, " R8 col_we"}, 256'(col_we), 256'(e_we));
    @(negedge clk);
    chk_quiet({tag, " R10 after"});
  endtask

  task automatic do_load(string tag, logic s, logic sel, logic [31:0] d);
    drive(2'd2, s, d, 4'hF, {8'h00, sel});
    if (s && !sel) m_mask  = d;
    if (s && sel)  m_color = d;
    chk_quiet(tag);
  endtask

  task automatic t_reset();
    chk_quiet("R1 reset");
    chk("R1 reset data", 256'(wr_data), 256'd0);
    do_write("R1 reset state block", 1'b1, 32'hFFFF_FFFF, 4'h0, 9'h0);
  endtask

  task automatic t_normal();
    do_write("R4 normal slot5", 1'b0, 32'hDEAD_BEEF, 4'h0, 9'h1A5);
    do_write("R4 normal slot0", 1'b0, 32'h1234_5678, 4'h0, 9'h008);
    do_write("R5 normal dqm", 1'b0, 32'hCAFE_F00D, 4'b1010, 9'h003);
  endtask

  task automatic t_loads();
    do_load("R2 mask load", 1'b1, 1'b0, 32'hF0F0_3C3C);
    do_write("R7 masked normal", 1'b0, 32'hFFFF_FFFF, 4'h0, 9'h007);
    do_load("R3 color load", 1'b1, 1'b1, 32'hA5A5_5A5A);
    do_write("R6 block uneven", 1'b1, 32'h8001_FF5A, 4'h0, 9'h0EF);
    do_write("R5 block dqm", 1'b1, 32'hFFFF_FFFF, 4'b0101, 9'h010);
  endtask

  task automatic t_ignored();
    do_load("R9 plain mode mask", 1'b0, 1'b0, 32'h0000_0000);
    do_load("R9 plain mode color", 1'b0, 1'b1, 32'h1111_1111);
    do_write("R7 write keeps mask", 1'b0, 32'h0000_0000, 4'h0, 9'h002);
    do_write("R9 R7 stored kept", 1'b1, 32'h0F0F_F0F0, 4'h0, 9'h1FF);
    drive(2'd0, 1'b1, 32'hFFFF_FFFF, 4'h0, 9'h0);
    chk_quiet("R10 idle");
    drive(2'd3, 1'b1, 32'hFFFF_FFFF, 4'h0, 9'h0);
    chk_quiet("R10 unused cmd");
    do_load("R2 mask reload", 1'b1, 1'b0, 32'hFFFF_FFFF);
    do_write("R2 unmasked block", 1'b1, 32'h0102_0408, 4'h0, 9'h055);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd = 2'd0; special = 1'b0; dq = '0; dqm = '0; col = '0;
    m_mask = 32'hFFFF_FFFF;
    m_color = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_normal();
    t_loads();
    t_ignored();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule